// File: doc/BRIEF.md
# Power Stage Reset Sequencer

This block sits beside a PWM modulator and drives the active-low reset line of a switching power stage. It keeps the stage in reset while the gate supply comes up and for a fixed wait afterwards, so that the bootstrap capacitors can charge. It lets the stage out of reset only when three conditions hold: the modulator reports that it is initialised, the stage reports no error, and the PWM stream it sends is toggling at a period inside a narrow window.

A built-in monitor times the PWM period in clock cycles from one rising edge to the next. It counts how many in-window periods arrive in a row, and it flags the stream as stuck when the line holds one level for too long. A constant high level therefore pulls the stage back into reset. When the stage reports an error, reset is pulsed low for a minimum time and released again once the error has cleared.

On a shutdown request, reset drops at once. The enable that lets the modulator produce PWM stays on for a set number of clocks after that and is then withdrawn. The stage never sees its PWM disappear while it is out of reset.

Top module: `pss_reset_sequencer`

## Requirements
- R1: After `supply_ok` rises, `stage_rst_n` stays low for PRECHG_CYC clock cycles of precharge. It can rise no earlier than the second edge after the precharge ends. During precharge `pwm_en` is high.
- R2: `pwm_valid` is high only after GOOD_RUNS consecutive rising-edge-to-rising-edge periods fall within PER_MIN..PER_MAX clocks, inclusive. A period outside the window clears the run. `stage_rst_n` is high only while `pwm_valid` is high and drops on the edge after `pwm_valid` falls.
- R3: If `pwm_in` holds either level for STUCK_CYC clocks, `pwm_valid` falls and `stage_rst_n` goes low.
- R4: `stage_rst_n` is high only while `mod_ready` is high. It falls on the first edge after `mod_ready` falls and rises on the first edge after `mod_ready` returns, provided the stream is valid.
- R5: On `shutdown_req`, `stage_rst_n` falls on the next edge while `pwm_en` stays high for DRAIN_CYC cycles. `pwm_en` falls on the following edge and stays low until the request is withdrawn. After that the sequence restarts with precharge.
- R6: A high `stage_fault` forces `stage_rst_n` low on the next edge. Reset stays low for at least RECOV_CYC cycles and until the fault clears. It is then released through the normal release check, one edge after recovery ends.
- R7: When `supply_ok` is low, both `stage_rst_n` and `pwm_en` are low from the next edge on.
- R8: While `rst` is high (synchronous, active high), `stage_rst_n`, `pwm_en` and `pwm_valid` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Gate supply is within range |
| mod_ready | input | 1 | Modulator is powered and initialised |
| pwm_in | input | 1 | PWM stream as sent to the stage (synchronised inside) |
| stage_fault | input | 1 | Latched error reported by the stage |
| shutdown_req | input | 1 | Request to stop the stage in order |
| stage_rst_n | output | 1 | Active-low reset to the power stage |
| pwm_en | output | 1 | Lets the modulator drive PWM |
| pwm_valid | output | 1 | The monitor judges the stream valid |

## Verification
The bench lands exactly on the precharge boundary. A design that released one cycle early, or that ignored the second check after precharge, would show reset high at the boundary edge. It feeds periods that are too long and too short, and it holds the line both high and low. A monitor that measured only one of these cases, or that accepted a single good period instead of a run, would release reset too soon or leave it high on a stuck line. The shutdown check samples the cycle just after the request and the last cycle of the drain. A design that gated PWM together with reset, or kept it for a cycle too many or too few, would be caught there. A one-cycle fault pulse checks that recovery still holds reset for its minimum time.

// File: rtl/pss_pkg.sv
package pss_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRECHG,
        ST_ARM,
        ST_RUN,
        ST_RECOVER,
        ST_DRAIN,
        ST_STOPPED
    } seq_state_e;

    typedef struct packed {
        logic valid;
        logic stuck;
    } pwm_status_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pss_pwm_monitor.sv
module pss_pwm_monitor
    import pss_pkg::*;
#(
    parameter int PER_MIN   = 125,
    parameter int PER_MAX   = 143,
    parameter int STUCK_CYC = 100,
    parameter int GOOD_RUNS = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        pwm_in,
    output pwm_status_t status
);
    localparam int CW = $clog2(max2(PER_MAX, STUCK_CYC) + 2);
    localparam int GW = $clog2(GOOD_RUNS + 1);
    localparam logic [CW-1:0] MIN_C = CW'(PER_MIN);
    localparam logic [CW-1:0] MAX_C = CW'(PER_MAX);
    localparam logic [CW-1:0] STK_C = CW'(STUCK_CYC);
    localparam logic [GW-1:0] GOOD_C = GW'(GOOD_RUNS);

    logic [2:0]    sync_q;
    logic          rise, fall;
    logic [CW-1:0] since_rise_q, since_rise_n;
    logic [CW-1:0] since_edge_q, since_edge_n;
    logic [GW-1:0] good_q, good_n;
    logic          stuck_n;

    always_comb begin
        rise = sync_q[1] & ~sync_q[2];
        fall = ~sync_q[1] & sync_q[2];
        since_rise_n = rise ? CW'(1)
                     : ((since_rise_q == '1) ? since_rise_q : since_rise_q + 1'b1);
        since_edge_n = (rise | fall) ? CW'(1)
                     : ((since_edge_q == '1) ? since_edge_q : since_edge_q + 1'b1);
        stuck_n = (since_edge_n >= STK_C);
        good_n  = good_q;
        if (rise) begin
            if (since_rise_q >= MIN_C && since_rise_q <= MAX_C)
                good_n = (good_q == GOOD_C) ? good_q : good_q + 1'b1;
            else
                good_n = '0;
        end else if (since_rise_n > MAX_C) begin
            good_n = '0;
        end
        if (stuck_n)
            good_n = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q       <= '0;
            since_rise_q <= '0;
            since_edge_q <= '0;
            good_q       <= '0;
            status       <= '0;
        end else begin
            sync_q       <= {sync_q[1:0], pwm_in};
            since_rise_q <= since_rise_n;
            since_edge_q <= since_edge_n;
            good_q       <= good_n;
            status.valid <= (good_n == GOOD_C) && !stuck_n;
            status.stuck <= stuck_n;
        end
    end

    // R3: a level held past the timeout leaves the stream invalid
    assert_stuck_invalid_R3: assert property (@(posedge clk) disable iff (rst)
        (since_edge_q >= STK_C) |=> !status.valid);

endmodule

// File: rtl/pss_phase_timer.sv
module pss_phase_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic [TW-1:0] limit,
    output logic          done
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt_q <= '0;
        else if (cnt_q != '1)
            cnt_q <= cnt_q + 1'b1;
    end

    assign done = (cnt_q >= limit - 1'b1);

endmodule

// File: rtl/pss_seq_fsm.sv
module pss_seq_fsm
    import pss_pkg::*;
#(
    parameter int PRECHG_CYC = 50000,
    parameter int RECOV_CYC  = 64,
    parameter int DRAIN_CYC  = 32,
    parameter int TW         = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          supply_ok,
    input  logic          mod_ready,
    input  logic          pwm_valid,
    input  logic          stage_fault,
    input  logic          shutdown_req,
    input  logic          tmr_done,
    output logic          tmr_clr,
    output logic [TW-1:0] tmr_limit,
    output logic          stage_rst_n,
    output logic          pwm_en
);
    seq_state_e state_q, state_n;

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:    if (!shutdown_req) state_n = ST_PRECHG;
            ST_PRECHG:  if (tmr_done) state_n = ST_ARM;
            ST_ARM:     if (pwm_valid && mod_ready && !stage_fault) state_n = ST_RUN;
            ST_RUN: begin
                if (stage_fault)                 state_n = ST_RECOVER;
                else if (!pwm_valid || !mod_ready) state_n = ST_ARM;
            end
            ST_RECOVER: if (tmr_done && !stage_fault) state_n = ST_ARM;
            ST_DRAIN:   if (tmr_done) state_n = ST_STOPPED;
            ST_STOPPED: if (!shutdown_req) state_n = ST_IDLE;
            default:    state_n = ST_IDLE;
        endcase
        if (shutdown_req && (state_q inside {ST_PRECHG, ST_ARM, ST_RUN, ST_RECOVER}))
            state_n = ST_DRAIN;
        if (!supply_ok)
            state_n = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_n;
    end

    always_comb begin
        unique case (state_q)
            ST_PRECHG:  tmr_limit = TW'(PRECHG_CYC);
            ST_RECOVER: tmr_limit = TW'(RECOV_CYC);
            ST_DRAIN:   tmr_limit = TW'(DRAIN_CYC);
            default:    tmr_limit = TW'(1);
        endcase
    end

    assign tmr_clr     = (state_n != state_q);
    assign stage_rst_n = (state_q == ST_RUN);
    assign pwm_en      = state_q inside {ST_PRECHG, ST_ARM, ST_RUN, ST_RECOVER, ST_DRAIN};

    // R1: the arm phase is entered from precharge only once the wait has run out
    assert_precharge_done_R1: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ARM && $past(state_q) == ST_PRECHG) |-> $past(tmr_done));
    // R2, R4: release only with a valid stream and a ready modulator
    assert_release_gated_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(stage_rst_n) |-> ($past(pwm_valid) && $past(mod_ready)));
    // R5: the stage is out of reset only while PWM is enabled
    assert_rst_within_en_R5: assert property (@(posedge clk) disable iff (rst)
        stage_rst_n |-> pwm_en);
    // R5: an orderly gate-off is preceded by a cycle of reset low
    assert_reset_before_gate_R5: assert property (@(posedge clk) disable iff (rst)
        ($fell(pwm_en) && $past(supply_ok)) |-> $past(!stage_rst_n));
    // R6: an error pulls reset low on the next edge
    assert_fault_low_R6: assert property (@(posedge clk) disable iff (rst)
        stage_fault |=> !stage_rst_n);
    // R7: supply loss drops both outputs
    assert_supply_loss_R7: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |=> (!stage_rst_n && !pwm_en));

endmodule

// File: rtl/pss_reset_sequencer.sv
module pss_reset_sequencer
    import pss_pkg::*;
#(
    parameter int PRECHG_CYC = 50000,
    parameter int PER_MIN    = 125,
    parameter int PER_MAX    = 143,
    parameter int STUCK_CYC  = 100,
    parameter int GOOD_RUNS  = 4,
    parameter int RECOV_CYC  = 64,
    parameter int DRAIN_CYC  = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_ok,
    input  logic mod_ready,
    input  logic pwm_in,
    input  logic stage_fault,
    input  logic shutdown_req,
    output logic stage_rst_n,
    output logic pwm_en,
    output logic pwm_valid
);
    localparam int TW = $clog2(max2(PRECHG_CYC, max2(RECOV_CYC, DRAIN_CYC)) + 1);

    pwm_status_t   mon_status;
    logic          tmr_clr, tmr_done;
    logic [TW-1:0] tmr_limit;

    pss_pwm_monitor #(
        .PER_MIN(PER_MIN), .PER_MAX(PER_MAX),
        .STUCK_CYC(STUCK_CYC), .GOOD_RUNS(GOOD_RUNS)
    ) u_mon (
        .clk(clk), .rst(rst), .pwm_in(pwm_in), .status(mon_status)
    );

    pss_phase_timer #(.TW(TW)) u_tmr (
        .clk(clk), .rst(rst), .clr(tmr_clr), .limit(tmr_limit), .done(tmr_done)
    );

    pss_seq_fsm #(
        .PRECHG_CYC(PRECHG_CYC), .RECOV_CYC(RECOV_CYC),
        .DRAIN_CYC(DRAIN_CYC), .TW(TW)
    ) u_fsm (
        .clk(clk), .rst(rst), .supply_ok(supply_ok), .mod_ready(mod_ready),
        .pwm_valid(mon_status.valid), .stage_fault(stage_fault),
        .shutdown_req(shutdown_req), .tmr_done(tmr_done), .tmr_clr(tmr_clr),
        .tmr_limit(tmr_limit), .stage_rst_n(stage_rst_n), .pwm_en(pwm_en)
    );

    assign pwm_valid = mon_status.valid;

endmodule

// File: tb/pss_reset_sequencer_tb.sv
module pss_reset_sequencer_tb;
    localparam int PRE   = 200;
    localparam int PMIN  = 10;
    localparam int PMAX  = 14;
    localparam int STK   = 10;
    localparam int GOOD  = 4;
    localparam int RECOV = 8;
    localparam int DRAIN = 5;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst, supply_ok, mod_ready, pwm_in, stage_fault, shutdown_req;
    logic stage_rst_n, pwm_en, pwm_valid;

    pss_reset_sequencer #(
        .PRECHG_CYC(PRE), .PER_MIN(PMIN), .PER_MAX(PMAX), .STUCK_CYC(STK),
        .GOOD_RUNS(GOOD), .RECOV_CYC(RECOV), .DRAIN_CYC(DRAIN)
    ) u_dut (
        .clk(clk), .rst(rst), .supply_ok(supply_ok), .mod_ready(mod_ready),
        .pwm_in(pwm_in), .stage_fault(stage_fault), .shutdown_req(shutdown_req),
        .stage_rst_n(stage_rst_n), .pwm_en(pwm_en), .pwm_valid(pwm_valid)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // modulator model: 0 = idle low, 1 = switching while enabled, 2 = stuck high
    int pmode = 0, pper = 12, phigh = 6, ph = 0;
    always @(negedge clk) begin
        if (pmode == 1 && pwm_en) begin
            pwm_in = (ph < phigh);
            ph = (ph + 1) % pper;
        end else if (pmode == 2) begin
            pwm_in = 1'b1;
        end else begin
            pwm_in = 1'b0;
            ph = 0;
        end
    end

    typedef struct {
        string tag;
        logic  r;
        logic  e;
        logic  v;
        bit    cv;
    } exp_t;
    exp_t exp_q[$];

    task automatic push_exp(input string tag, input logic r, input logic e,
                            input logic v, input bit cv);
        exp_t it;
        it.tag = tag; it.r = r; it.e = e; it.v = v; it.cv = cv;
        exp_q.push_back(it);
    endtask

    exp_t cur;
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            cur = exp_q.pop_front();
            n_cmp++;
            if (stage_rst_n !== cur.r || pwm_en !== cur.e || (cur.cv && pwm_valid !== cur.v)) begin
                n_bad++;
                $display("FAIL %s: got rst_n=%b en=%b valid=%b, expected rst_n=%b en=%b valid=%b",
                         cur.tag, stage_rst_n, pwm_en, pwm_valid, cur.r, cur.e,
                         cur.cv ? cur.v : pwm_valid);
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got no completion, expected end of sequence");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1; supply_ok = 0; mod_ready = 0; pwm_in = 0;
        stage_fault = 0; shutdown_req = 0;
        cyc(3);
        push_exp("R8 reset state", 0, 0, 0, 1);
        cyc(1); rst = 0;
        cyc(1);

        // R1 precharge with a valid stream from the start
        supply_ok = 1; mod_ready = 1; pmode = 1;
        cyc(PRE - 10); push_exp("R1 mid precharge", 0, 1, 0, 0);
        cyc(10);       push_exp("R1 last precharge cycle", 0, 1, 0, 0);
        cyc(1);        push_exp("R1 arm edge still in reset", 0, 1, 1, 1);
        cyc(1);        push_exp("R1 released after precharge", 1, 1, 1, 1);

        // R2 frequency window
        pper = 20; phigh = 10;
        cyc(60); push_exp("R2 period too long", 0, 1, 0, 1);
        pper = 6; phigh = 3;
        cyc(60); push_exp("R2 period too short", 0, 1, 0, 1);
        pper = 12; phigh = 6;
        cyc(30); push_exp("R2 run of good periods not yet complete", 0, 1, 0, 1);
        cyc(70); push_exp("R2 released after good run", 1, 1, 1, 1);

        // R3 stuck levels
        pmode = 2;
        cyc(25); push_exp("R3 stuck high", 0, 1, 0, 1);
        pmode = 1;
        cyc(100); push_exp("R3 recovered from stuck high", 1, 1, 1, 1);
        pmode = 0;
        cyc(25); push_exp("R3 stuck low", 0, 1, 0, 1);
        pmode = 1;
        cyc(100); push_exp("R3 recovered from stuck low", 1, 1, 1, 1);

        // R4 modulator readiness
        mod_ready = 0;
        cyc(1);  push_exp("R4 not ready drops reset", 0, 1, 1, 1);
        cyc(20); push_exp("R4 not ready holds reset", 0, 1, 1, 1);
        mod_ready = 1;
        cyc(1);  push_exp("R4 ready releases reset", 1, 1, 1, 1);

        // R6 long fault
        stage_fault = 1;
        cyc(1);  push_exp("R6 fault drops reset", 0, 1, 1, 1);
        cyc(30); push_exp("R6 fault held", 0, 1, 1, 1);
        stage_fault = 0;
        cyc(1);  push_exp("R6 recovery ends", 0, 1, 1, 1);
        cyc(1);  push_exp("R6 released after fault", 1, 1, 1, 1);
        // R6 one-cycle fault still gets the minimum low time
        stage_fault = 1;
        cyc(1); stage_fault = 0;
        cyc(RECOV); push_exp("R6 minimum low time", 0, 1, 1, 1);
        cyc(1);     push_exp("R6 released after minimum", 1, 1, 1, 1);

        // R5 orderly shutdown
        shutdown_req = 1;
        cyc(1);         push_exp("R5 reset first", 0, 1, 1, 1);
        cyc(DRAIN - 1); push_exp("R5 pwm kept during drain", 0, 1, 1, 0);
        cyc(1);         push_exp("R5 pwm gated after drain", 0, 0, 0, 0);
        cyc(10);        push_exp("R5 stays stopped", 0, 0, 0, 0);
        mod_ready = 0;
        shutdown_req = 0;
        cyc(2);         push_exp("R5 restart enters precharge", 0, 1, 0, 0);

        // R4 modulator not ready after precharge
        cyc(PRE + 20);  push_exp("R4 held in reset until ready", 0, 1, 1, 1);
        mod_ready = 1;
        cyc(1);         push_exp("R4 release when ready", 1, 1, 1, 1);

        // R7 supply loss
        supply_ok = 0;
        cyc(1); push_exp("R7 supply loss", 0, 0, 0, 0);
        cyc(5); push_exp("R7 supply loss held", 0, 0, 0, 0);

        cyc(2);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule